// File: doc/BRIEF.md
# Sense-Before-Write Crosspoint Memory Controller

This controller sequences byte accesses to a resistive crosspoint array whose cells are complementary resistor pairs: a stored 1 has resistor A low-resistance and resistor B high-resistance, and a stored 0 is the reverse. It does not drive analog voltages. It produces two-bit level codes for every global wordline pair, every bitline and the block switches, and it drives an active-low strobe for an external clocked sense amplifier whose byte result comes back on `sa_out`.

A read senses the addressed byte once and returns it. A write never pulses blindly. It first senses the stored byte and compares it with the new data. It then writes only the bits that differ. Bits that already hold the target value see no full-voltage stress, which protects cells whose low-resistance state would otherwise drift with repeated pulses. A one-cycle completion pulse ends every operation, and requests are taken only when the controller is idle.

Top module: `xpoint_sbw_ctrl`

## Requirements
- R1: After reset, every level code is 0 (ground), all block switches are open, `sa_en_n` is 1, `done` is 0 and `dout` is 0.
- R2: A read keeps `sa_en_n` low for exactly one cycle, the first cycle after acceptance. In that cycle the selected row has code 2 (read) on its A wordline and code 0 on its B wordline. `done` rises in the second cycle after acceptance, and `dout` then holds the sensed byte.
- R3: The block is chosen by address bits [7:2] and the row within the block by bits [1:0]. Only `sw_close[block]` is set while the array is accessed, and all switches are open otherwise.
- R4: Every write senses first. At the write's `done`, `dout` holds the byte that was stored before the write.
- R5: A write of data equal to the stored byte produces no write phase and no full-voltage cycle on any cell, and `done` rises in the third cycle after acceptance.
- R6: During write phases, bitlines of bits not being written carry code 1 (half level). Each bit that changes sees exactly 2*PULSE_CYC full-voltage cycles, and no other cell sees any.
- R7: Bits changing 0 to 1 are written in a phase where the selected row has A = code 3 and B = code 0. Their bitlines are at code 0 for PULSE_CYC cycles (A set) and then at code 3 for PULSE_CYC cycles (B reset).
- R8: Bits changing 1 to 0 are written in a phase where the selected row has A = code 0 and B = code 3. Their bitlines are at code 0 and then at code 3 for PULSE_CYC cycles each. This phase follows the 0-to-1 phase, and a phase with no bits is skipped. `done` therefore rises in cycle 3 + 2*PULSE_CYC*(number of phases present).
- R9: During write phases, the unselected rows of the addressed block carry code 1 on both A and B.
- R10: When `we` and `re` are both high, the request is a write.
- R11: Requests arriving while an operation is in progress are ignored.
- R12: `done` is high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write request |
| re | input | 1 | Read request |
| addr | input | 8 | Byte address: block [7:2], row [1:0] |
| din | input | 8 | Write data |
| sa_out | input | 8 | Sense amplifier result, valid while `sa_en_n` is low |
| sa_en_n | output | 1 | Active-low sense strobe |
| gwla_lvl | output | 8 | A-wordline level code per row, 2 bits each, row r at [2r+1:2r] |
| gwlb_lvl | output | 8 | B-wordline level code per row, same packing |
| bl_lvl | output | 16 | Bitline level code per data bit, bit i at [2i+1:2i] |
| sw_close | output | 64 | Local-to-global wordline switch closure per block |
| dout | output | 8 | Sensed byte |
| done | output | 1 | One-cycle end-of-operation pulse |

Level codes: 0 ground, 1 half write level, 2 read level, 3 full write level.

## Verification
Within one write, a bit being set and a bit being cleared can share the operation, so the two write phases fall back to back and each bit's bitline must follow its own phase. The bench provokes this with mixed-direction data sweeps at one address. It judges every write-phase cycle against the level pattern computed from the old and new bytes, and counts full-voltage cycles per cell in a behavioural array model. New requests that land during a running write are also driven, and the bench checks that the extra requests cause neither a second completion nor a change in stored data.

// File: rtl/xpoint_pkg.sv
package xpoint_pkg;
   localparam int LVL_W = 2;

   typedef enum logic [1:0] {
      LV_GND   = 2'd0,
      LV_HALF  = 2'd1,
      LV_READ  = 2'd2,
      LV_WRITE = 2'd3
   } lvl_e;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SENSE = 3'd1,
      PH_CMP   = 3'd2,
      PH_WUP   = 3'd3,
      PH_WDN   = 3'd4,
      PH_DONE  = 3'd5
   } phase_e;
endpackage

// File: rtl/xp_addr_dec.sv
module xp_addr_dec #(
   parameter int ADDR_W = 8,
   parameter int BLK_W  = 6
) (
   input  logic [ADDR_W-1:0]                addr,
   output logic [(1<<BLK_W)-1:0]            blk_oh,
   output logic [(1<<(ADDR_W-BLK_W))-1:0]   row_oh
);
   localparam int ROW_W  = ADDR_W - BLK_W;
   localparam int NBLK   = 1 << BLK_W;
   localparam int NROW   = 1 << ROW_W;

   logic [BLK_W-1:0] blk_idx;
   logic [ROW_W-1:0] row_idx;

   assign blk_idx = addr[ADDR_W-1 -: BLK_W];
   assign row_idx = addr[ROW_W-1:0];

   for (genvar g = 0; g < NBLK; g++) begin : g_blk
      assign blk_oh[g] = (blk_idx == BLK_W'(g));
   end

   for (genvar r = 0; r < NROW; r++) begin : g_row
      assign row_oh[r] = (row_idx == ROW_W'(r));
   end
endmodule

// File: rtl/xp_seq.sv
module xp_seq
   import xpoint_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int PULSE_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] sa_out,
   output phase_e            phase,
   output logic              sub_rst,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] up_mask,
   output logic [DATA_W-1:0] dn_mask,
   output logic [DATA_W-1:0] dout,
   output logic              sa_en_n,
   output logic              done
);
   localparam int LAST  = 2*PULSE_CYC - 1;
   localparam int CNT_W = $clog2(2*PULSE_CYC + 1);

   phase_e            ph_q, ph_d;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] din_q, dout_q, diff;
   logic              wr_q, last_cyc;

   assign diff     = din_q ^ dout_q;
   assign up_mask  = diff & din_q;
   assign dn_mask  = diff & ~din_q;
   assign last_cyc = (cnt_q == CNT_W'(LAST));

   always_comb begin
      ph_d = ph_q;
      case (ph_q)
         PH_IDLE:  if (we || re) ph_d = PH_SENSE;
         PH_SENSE: ph_d = wr_q ? PH_CMP : PH_DONE;
         PH_CMP:   ph_d = (|up_mask) ? PH_WUP : ((|dn_mask) ? PH_WDN : PH_DONE);
         PH_WUP:   if (last_cyc) ph_d = (|dn_mask) ? PH_WDN : PH_DONE;
         PH_WDN:   if (last_cyc) ph_d = PH_DONE;
         PH_DONE:  ph_d = PH_IDLE;
         default:  ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         addr_q <= '0;
         din_q  <= '0;
         dout_q <= '0;
         wr_q   <= 1'b0;
      end else begin
         ph_q <= ph_d;
         if (ph_d != ph_q) cnt_q <= '0;
         else              cnt_q <= cnt_q + 1'b1;
         if (ph_q == PH_IDLE && (we || re)) begin
            addr_q <= addr;
            din_q  <= din;
            wr_q   <= we;
         end
         if (ph_q == PH_SENSE) dout_q <= sa_out;
      end
   end

   assign phase   = ph_q;
   assign sub_rst = (cnt_q >= CNT_W'(PULSE_CYC));
   assign dout    = dout_q;
   assign sa_en_n = (ph_q != PH_SENSE);
   assign done    = (ph_q == PH_DONE);

   // R2
   sense_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sa_en_n |=> sa_en_n);
   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R11
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q != PH_IDLE) |=> ($stable(addr_q) && $stable(din_q)));
   // R5
   equal_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_CMP && din_q == dout_q) |=> done);
   // R4
   write_senses_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_SENSE && wr_q) |=> (ph_q == PH_CMP));
endmodule

// File: rtl/xp_line_drv.sv
module xp_line_drv
   import xpoint_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ROWS     = 4,
   parameter int N_BLOCKS = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  phase_e                  phase,
   input  logic                    sub_rst,
   input  logic [ROWS-1:0]         row_oh,
   input  logic [N_BLOCKS-1:0]     blk_oh,
   input  logic [DATA_W-1:0]       up_mask,
   input  logic [DATA_W-1:0]       dn_mask,
   output logic [LVL_W*ROWS-1:0]   gwla,
   output logic [LVL_W*ROWS-1:0]   gwlb,
   output logic [LVL_W*DATA_W-1:0] bl,
   output logic [N_BLOCKS-1:0]     sw_close
);
   logic active;

   assign active   = (phase == PH_SENSE) || (phase == PH_WUP) || (phase == PH_WDN);
   assign sw_close = active ? blk_oh : '0;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      lvl_e a_lv, b_lv;
      always_comb begin
         a_lv = LV_GND;
         b_lv = LV_GND;
         case (phase)
            PH_SENSE: a_lv = row_oh[r] ? LV_READ : LV_GND;
            PH_WUP: begin
               a_lv = row_oh[r] ? LV_WRITE : LV_HALF;
               b_lv = row_oh[r] ? LV_GND   : LV_HALF;
            end
            PH_WDN: begin
               a_lv = row_oh[r] ? LV_GND   : LV_HALF;
               b_lv = row_oh[r] ? LV_WRITE : LV_HALF;
            end
            default: ;
         endcase
      end
      assign gwla[r*LVL_W +: LVL_W] = a_lv;
      assign gwlb[r*LVL_W +: LVL_W] = b_lv;
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      lvl_e b_lv;
      logic hit;
      always_comb begin
         hit  = 1'b0;
         b_lv = LV_GND;
         if (phase == PH_WUP || phase == PH_WDN) begin
            hit  = (phase == PH_WUP) ? up_mask[i] : dn_mask[i];
            b_lv = hit ? (sub_rst ? LV_WRITE : LV_GND) : LV_HALF;
         end
      end
      assign bl[i*LVL_W +: LVL_W] = b_lv;
   end

   // R3
   sw_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sw_close));
   // R7
   wup_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WUP) |-> (up_mask != '0));
   // R8
   wdn_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WDN) |-> (dn_mask != '0));
endmodule

// File: rtl/xpoint_sbw_ctrl.sv
module xpoint_sbw_ctrl
   import xpoint_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int N_BLOCKS  = 64,
   parameter int PULSE_CYC = 2
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         we,
   input  logic                                         re,
   input  logic [ADDR_W-1:0]                            addr,
   input  logic [DATA_W-1:0]                            din,
   input  logic [DATA_W-1:0]                            sa_out,
   output logic                                         sa_en_n,
   output logic [2*(1<<(ADDR_W-$clog2(N_BLOCKS)))-1:0]  gwla_lvl,
   output logic [2*(1<<(ADDR_W-$clog2(N_BLOCKS)))-1:0]  gwlb_lvl,
   output logic [2*DATA_W-1:0]                          bl_lvl,
   output logic [N_BLOCKS-1:0]                          sw_close,
   output logic [DATA_W-1:0]                            dout,
   output logic                                         done
);
   localparam int BLK_W = $clog2(N_BLOCKS);
   localparam int ROW_W = ADDR_W - BLK_W;
   localparam int ROWS  = 1 << ROW_W;

   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("PULSE_CYC must be at least 1");
   end
   if ((1 << BLK_W) != N_BLOCKS || BLK_W >= ADDR_W) begin : g_bad_blocks
      $error("N_BLOCKS must be a power of two below 2**ADDR_W");
   end
   if (LVL_W != 2) begin : g_bad_lvl
      $error("level code width must be 2");
   end

   phase_e            phase;
   logic              sub_rst;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] up_mask, dn_mask;
   logic [N_BLOCKS-1:0] blk_oh;
   logic [ROWS-1:0]     row_oh;

   xp_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .we(we), .re(re), .addr(addr), .din(din),
      .sa_out(sa_out), .phase(phase), .sub_rst(sub_rst), .addr_q(addr_q),
      .up_mask(up_mask), .dn_mask(dn_mask), .dout(dout),
      .sa_en_n(sa_en_n), .done(done)
   );

   xp_addr_dec #(
      .ADDR_W(ADDR_W), .BLK_W(BLK_W)
   ) u_dec (
      .addr(addr_q), .blk_oh(blk_oh), .row_oh(row_oh)
   );

   xp_line_drv #(
      .DATA_W(DATA_W), .ROWS(ROWS), .N_BLOCKS(N_BLOCKS)
   ) u_drv (
      .clk(clk), .rst_n(rst_n), .phase(phase), .sub_rst(sub_rst),
      .row_oh(row_oh), .blk_oh(blk_oh), .up_mask(up_mask), .dn_mask(dn_mask),
      .gwla(gwla_lvl), .gwlb(gwlb_lvl), .bl(bl_lvl), .sw_close(sw_close)
   );

   // R3
   sense_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sa_en_n |-> ($countones(sw_close) == 1));
   // R12
   done_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (sw_close == '0));
endmodule

// File: tb/xpoint_sbw_ctrl_bench.sv
module xpoint_sbw_ctrl_bench;
   localparam int P     = 2;
   localparam int NBLK  = 64;
   localparam int ROWS  = 4;
   localparam int NBYTE = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0, re = 1'b0;
   logic [7:0]  addr = '0, din = '0;
   logic [7:0]  sa_out;
   logic        sa_en_n, done;
   logic [7:0]  gwla_lvl, gwlb_lvl, dout;
   logic [15:0] bl_lvl;
   logic [63:0] sw_close;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   bit ra_low [0:NBYTE-1][0:7];
   bit rb_low [0:NBYTE-1][0:7];
   int pcnt   [0:NBYTE-1][0:7];
   int tot_pulse = 0;
   int sense_cyc = 0;
   logic [7:0] exp_mem [0:NBYTE-1];

   always #2 clk = ~clk;

   xpoint_sbw_ctrl #(.PULSE_CYC(P)) u_xpoint_sbw_ctrl (
      .clk(clk), .rst_n(rst_n), .we(we), .re(re), .addr(addr), .din(din),
      .sa_out(sa_out), .sa_en_n(sa_en_n), .gwla_lvl(gwla_lvl),
      .gwlb_lvl(gwlb_lvl), .bl_lvl(bl_lvl), .sw_close(sw_close),
      .dout(dout), .done(done)
   );

   function automatic int volt(input logic [1:0] c);
      return (c == 2'd3) ? 2 : ((c == 2'd1) ? 1 : 0);
   endfunction

   // behavioural cell array and sense amplifier
   always_comb begin
      sa_out = '0;
      if (!sa_en_n)
         for (int b = 0; b < NBLK; b++)
            for (int r = 0; r < ROWS; r++)
               if (sw_close[b] && gwla_lvl[r*2 +: 2] == 2'd2 && gwlb_lvl[r*2 +: 2] == 2'd0)
                  for (int i = 0; i < 8; i++)
                     sa_out[i] = ra_low[b*ROWS+r][i] && !rb_low[b*ROWS+r][i];
   end

   always @(negedge clk) begin
      if (!sa_en_n) sense_cyc++;
      for (int b = 0; b < NBLK; b++)
         if (sw_close[b])
            for (int r = 0; r < ROWS; r++)
               for (int i = 0; i < 8; i++) begin
                  int va, vb, ix;
                  ix = b*ROWS + r;
                  va = volt(gwla_lvl[r*2 +: 2]) - volt(bl_lvl[i*2 +: 2]);
                  vb = volt(gwlb_lvl[r*2 +: 2]) - volt(bl_lvl[i*2 +: 2]);
                  if (va == 2)  ra_low[ix][i] = 1'b1;
                  if (va == -2) ra_low[ix][i] = 1'b0;
                  if (vb == 2)  rb_low[ix][i] = 1'b1;
                  if (vb == -2) rb_low[ix][i] = 1'b0;
                  if (va == 2 || va == -2 || vb == 2 || vb == -2) begin
                     pcnt[ix][i]++;
                     tot_pulse++;
                  end
               end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int wlat(input logic [7:0] old_v, input logic [7:0] new_v);
      logic [7:0] m;
      int ph;
      m  = old_v ^ new_v;
      ph = ((m & new_v) != 0 ? 1 : 0) + ((m & ~new_v) != 0 ? 1 : 0);
      return 3 + 2*P*ph;
   endfunction

   task automatic op(input bit w, input bit r, input logic [7:0] a, input logic [7:0] d,
                     output int cyc, output logic [7:0] q);
      @(negedge clk);
      we = w; re = r; addr = a; din = d;
      @(negedge clk);
      we = 1'b0; re = 1'b0;
      cyc = 1;
      while (!done && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
      q = dout;
      @(negedge clk);
      // R12 done lasts one cycle
      chk(done == 1'b0, "R12", int'(done), 0);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit both);
      int cyc, t0, bad;
      int p0 [0:7];
      logic [7:0] q, old_v, m;
      old_v = exp_mem[a];
      m     = old_v ^ d;
      t0    = tot_pulse;
      for (int i = 0; i < 8; i++) p0[i] = pcnt[a][i];
      op(1'b1, both, a, d, cyc, q);
      chk(cyc == wlat(old_v, d), (m == 0) ? "R5" : "R8", cyc, wlat(old_v, d));
      chk(q == old_v, "R4", q, old_v);
      chk(tot_pulse - t0 == $countones(m)*2*P, (m == 0) ? "R5" : "R6",
          tot_pulse - t0, $countones(m)*2*P);
      bad = 0;
      for (int i = 0; i < 8; i++)
         if (pcnt[a][i] - p0[i] != (m[i] ? 2*P : 0)) bad++;
      chk(bad == 0, "R6", bad, 0);
      exp_mem[a] = d;
   endtask

   task automatic rd(input logic [7:0] a);
      int cyc, s0;
      logic [7:0] q;
      s0 = sense_cyc;
      op(1'b0, 1'b1, a, 8'h00, cyc, q);
      chk(cyc == 2, "R2", cyc, 2);
      chk(q == exp_mem[a], "R2", q, exp_mem[a]);
      chk(sense_cyc - s0 == 1, "R2", sense_cyc - s0, 1);
   endtask

   // cycle-by-cycle level pattern of one write
   task automatic shape_wr(input logic [7:0] a, input logic [7:0] d);
      logic [7:0] up, dn, sel;
      int r, b, nph, k, ph_k, sub;
      up  = (exp_mem[a] ^ d) & d;
      dn  = (exp_mem[a] ^ d) & ~d;
      r   = a[1:0];
      b   = a[7:2];
      nph = (up != 0 ? 1 : 0) + (dn != 0 ? 1 : 0);
      @(negedge clk);
      we = 1'b1; addr = a; din = d;
      @(negedge clk);
      we = 1'b0;
      // k = 1: sense cycle
      chk(sa_en_n == 1'b0 && gwla_lvl[r*2 +: 2] == 2'd2 && gwlb_lvl[r*2 +: 2] == 2'd0,
          "R2", {sa_en_n, gwla_lvl[r*2 +: 2]}, 2);
      chk(sw_close == (64'd1 << b), "R3", $countones(sw_close), 1);
      @(negedge clk);
      for (k = 3; k < 3 + 2*P*nph; k++) begin
         @(negedge clk);
         ph_k = (k - 3) / (2*P);
         sub  = ((k - 3) % (2*P)) >= P;
         if (ph_k == 0 && up != 0) begin
            sel = up;
            chk(gwla_lvl[r*2 +: 2] == 2'd3 && gwlb_lvl[r*2 +: 2] == 2'd0, "R7",
                {gwla_lvl[r*2 +: 2], gwlb_lvl[r*2 +: 2]}, 4'b1100);
         end else begin
            sel = dn;
            chk(gwla_lvl[r*2 +: 2] == 2'd0 && gwlb_lvl[r*2 +: 2] == 2'd3, "R8",
                {gwla_lvl[r*2 +: 2], gwlb_lvl[r*2 +: 2]}, 4'b0011);
         end
         for (int i = 0; i < 8; i++) begin
            int ev;
            ev = sel[i] ? (sub ? 3 : 0) : 1;
            chk(bl_lvl[i*2 +: 2] == 2'(ev), sel[i] ? "R7" : "R6", bl_lvl[i*2 +: 2], ev);
         end
         for (int rr = 0; rr < ROWS; rr++)
            if (rr != r)
               chk(gwla_lvl[rr*2 +: 2] == 2'd1 && gwlb_lvl[rr*2 +: 2] == 2'd1, "R9",
                   {gwla_lvl[rr*2 +: 2], gwlb_lvl[rr*2 +: 2]}, 4'b0101);
      end
      @(negedge clk);
      chk(done == 1'b1, "R8", int'(done), 1);
      @(negedge clk);
      exp_mem[a] = d;
   endtask

   initial begin
      for (int x = 0; x < NBYTE; x++) begin
         exp_mem[x] = '0;
         for (int i = 0; i < 8; i++) begin
            ra_low[x][i] = 1'b0;
            rb_low[x][i] = 1'b1;
            pcnt[x][i]   = 0;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(gwla_lvl == 0 && gwlb_lvl == 0 && bl_lvl == 0, "R1", int'(bl_lvl), 0);
      chk(sw_close == 0, "R1", $countones(sw_close), 0);
      chk(sa_en_n == 1'b1 && done == 1'b0 && dout == 0, "R1", {sa_en_n, done}, 2);

      rd(8'h13);
      // R3: every address gets its own value
      for (int a = 0; a < NBYTE; a++) wr(8'(a), 8'((a*37 + 5) & 8'hFF), 1'b0);
      for (int a = 0; a < NBYTE; a++) rd(8'(a));
      // R5: identical rewrite
      wr(8'h44, exp_mem[8'h44], 1'b0);
      wr(8'h00, exp_mem[8'h00], 1'b0);
      // data sweep at one address, mixed directions
      for (int d = 0; d < 256; d++) wr(8'h5A, 8'(d ^ (d << 3)), 1'b0);
      rd(8'h5A);
      // R7 / R8 / R9 level patterns
      shape_wr(8'hC1, 8'h00);
      shape_wr(8'hC1, 8'h0F);
      shape_wr(8'hC1, 8'h3C);
      shape_wr(8'hC1, 8'hC3);
      rd(8'hC1);
      // R10 both requests: write wins
      wr(8'h77, 8'h9E, 1'b1);
      rd(8'h77);
      // R11 requests while busy
      begin
         int dn_cnt;
         logic [7:0] d1;
         d1 = ~exp_mem[8'h21];
         dn_cnt = 0;
         @(negedge clk);
         we = 1'b1; addr = 8'h21; din = d1;
         @(negedge clk);
         addr = 8'h22; din = 8'h5A; re = 1'b1;
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (done) dn_cnt++;
         end
         we = 1'b0; re = 1'b0;
         for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (done) dn_cnt++;
         end
         chk(dn_cnt == 1, "R11", dn_cnt, 1);
         exp_mem[8'h21] = d1;
      end
      rd(8'h21);
      rd(8'h22);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule